// File: doc/BRIEF.md
# Instruction Fetch Front End with Branch Redirect

This block is the front end of a small in-order pipeline. It holds the program counter and issues one instruction-memory read per cycle. The address grows by one 32-bit word (4 bytes) per issued read, because there is no branch prediction. The memory answers exactly one cycle after a request. The returned word moves through an in-flight slot into a decode register. The decode register feeds the rest of the pipeline through a valid/ready pair. A fetch issued in cycle t reaches the decode outputs in cycle t+2.

A later stage resolves branches. When it finds a taken branch or jump, it raises `br_taken` for one cycle together with `br_target`. The caller forms the target relative to the PC that the branch carried in the decode stage. The front end then discards every younger instruction and restarts fetch at the target. There is no delay slot.

A build-time parameter selects where resolution happens:
- In decode (the default), the redirect arrives in the same cycle the branch leaves decode. This costs two empty decode cycles.
- In execute, the redirect arrives one cycle later, while the next instruction already sits in decode. That instruction is suppressed, and the cost is three empty cycles.

Back-pressure rules: an instruction transfers when `dec_valid` and `dec_ready` are both high. While `dec_valid` is high and `dec_ready` is low, the front end holds `dec_pc` and `dec_instr` steady. `dec_valid` may drop only on a redirect. Holding `dec_ready` low is the stall request, and it freezes the program counter and all stage registers. A word already in flight when the stall begins is parked, not lost. The memory side has no ready: `imem_rdata` must be valid one cycle after every `imem_req`.

Top module: `fetch_frontend`

## Requirements
- R1: In every cycle with `imem_req` high, the next cycle's `imem_addr` is the current one plus 4.
- R2: In the first cycle after `rst` falls, `dec_valid` is low, `imem_addr` equals `RESET_VEC`, and `imem_req` is high when `dec_ready` is high.
- R3: Words appear on the decode outputs in program order. Each word's `dec_instr` is the value memory returned for the address shown on `dec_pc`.
- R4: In the cycle after `br_taken` is high, `imem_addr` equals the `br_target` presented with it.
- R5: With `RESOLVE` = decode (encoding 0), `br_taken` accompanies the transfer of the branch from decode. Exactly 2 cycles with `dec_valid` low then separate the branch transfer from the target's transfer.
- R6: With `RESOLVE` = execute (encoding 1), `br_taken` comes one cycle after the branch transfers, and `dec_valid` is low in that cycle. Exactly 3 cycles with `dec_valid` low then separate the branch transfer from the target's transfer.
- R7: The instruction transferred right after a taken branch is always the one at the target; the fall-through word never transfers.
- R8: While `dec_ready` is low and no redirect is present, `imem_req` is low and `imem_addr` is unchanged. A pending decode word keeps its `dec_pc` and `dec_instr`, and no word is lost or repeated once `dec_ready` returns.
- R9: A redirect that arrives while `dec_ready` is low still takes effect: the next fetch address is the target and wrong-path words are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_req | output | 1 | Read request to instruction memory |
| imem_addr | output | ADDR_W | Byte address of the requested word (current PC) |
| imem_rdata | input | INSN_W | Word returned one cycle after a request |
| dec_ready | input | 1 | Downstream can accept; low is the stall request |
| br_taken | input | 1 | Taken branch or jump resolved this cycle |
| br_target | input | ADDR_W | Redirect address, valid with `br_taken` |
| dec_valid | output | 1 | Decode-stage instruction is valid |
| dec_pc | output | ADDR_W | PC of the decode-stage instruction |
| dec_instr | output | INSN_W | Decode-stage instruction word |

## Verification
A redirect and a stall can fall in the same cycle, and that case is what R9 is about. The bench provokes it deliberately: after every third branch it pulls `dec_ready` low in the cycle after the branch transfers. In execute-resolution mode, that is exactly the cycle that carries `br_taken`. The result is judged from the next cycle's fetch address, from the decode stream that follows (which must continue at the target with no fall-through word), and from the frozen decode outputs during the remaining stall. The counted penalty is compared with 2 or 3 only for branch windows free of stalls.

// File: rtl/fe_pkg.sv
package fe_pkg;

  // Where the taken-branch decision is made; changes the redirect penalty.
  typedef enum logic {
    RESOLVE_DECODE  = 1'b0,
    RESOLVE_EXECUTE = 1'b1
  } fe_resolve_e;

endpackage

// File: rtl/fe_pc_gen.sv
// Program counter: linear advance, redirect, freeze on hold.
module fe_pc_gen #(
  parameter int unsigned          ADDR_W    = 32,
  parameter int unsigned          STEP      = 4,
  parameter logic [ADDR_W-1:0]    RESET_VEC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] redirect_pc,
  output logic              issue,
  output logic [ADDR_W-1:0] issue_pc
);

  localparam logic [ADDR_W-1:0] INC = ADDR_W'(STEP);

  logic [ADDR_W-1:0] pc_q;

  // A redirect cycle issues nothing: the current PC is already wrong-path.
  assign issue    = ~hold & ~redirect;
  assign issue_pc = pc_q;

  always_ff @(posedge clk) begin
    if (rst)           pc_q <= RESET_VEC;
    else if (redirect) pc_q <= redirect_pc;
    else if (issue)    pc_q <= pc_q + INC;
  end

endmodule

// File: rtl/fe_resp_track.sv
// Tracks the read in flight and parks a returning word while held.
module fe_resp_track #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned INSN_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              redirect,
  input  logic              issue,
  input  logic [ADDR_W-1:0] issue_pc,
  input  logic [INSN_W-1:0] mem_word,
  output logic              src_valid,
  output logic [ADDR_W-1:0] src_pc,
  output logic [INSN_W-1:0] src_word
);

  logic              infl_valid;
  logic [ADDR_W-1:0] infl_pc;
  logic              park_valid;
  logic [ADDR_W-1:0] park_pc;
  logic [INSN_W-1:0] park_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      infl_valid <= 1'b0;
      infl_pc    <= '0;
    end else begin
      infl_valid <= issue & ~redirect;
      if (issue) infl_pc <= issue_pc;
    end
  end

  // Only the first held cycle can see an arrival (no issue while held),
  // and the parked word is consumed on release, so one entry suffices.
  always_ff @(posedge clk) begin
    if (rst || redirect) begin
      park_valid <= 1'b0;
    end else if (hold && infl_valid) begin
      park_valid <= 1'b1;
      park_pc    <= infl_pc;
      park_word  <= mem_word;
    end else if (!hold) begin
      park_valid <= 1'b0;
    end
  end

  assign src_valid = park_valid | infl_valid;
  assign src_pc    = park_valid ? park_pc   : infl_pc;
  assign src_word  = park_valid ? park_word : mem_word;

endmodule

// File: rtl/fe_dec_stage.sv
// Decode register with flush and the mode-dependent kill of its output.
module fe_dec_stage
  import fe_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned INSN_W  = 32,
  parameter fe_resolve_e RESOLVE = RESOLVE_DECODE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              redirect,
  input  logic              src_valid,
  input  logic [ADDR_W-1:0] src_pc,
  input  logic [INSN_W-1:0] src_word,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_pc,
  output logic [INSN_W-1:0] out_word
);

  logic d_valid;

  always_ff @(posedge clk) begin
    if (rst || redirect) begin
      d_valid <= 1'b0;
    end else if (!hold) begin
      d_valid <= src_valid;
      if (src_valid) begin
        out_pc   <= src_pc;
        out_word <= src_word;
      end
    end
  end

  generate
    if (RESOLVE == RESOLVE_EXECUTE) begin : g_late
      // The redirect names the instruction ahead; the one here is wrong-path.
      assign out_valid = d_valid & ~redirect;
    end else begin : g_early
      // The redirect names the instruction here, which leaves normally.
      assign out_valid = d_valid;
    end
  endgenerate

endmodule

// File: rtl/fetch_frontend.sv
module fetch_frontend
  import fe_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       INSN_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = 32'h0000_1000,
  parameter fe_resolve_e       RESOLVE   = RESOLVE_DECODE
) (
  input  logic              clk,
  input  logic              rst,
  output logic              imem_req,
  output logic [ADDR_W-1:0] imem_addr,
  input  logic [INSN_W-1:0] imem_rdata,
  input  logic              dec_ready,
  input  logic              br_taken,
  input  logic [ADDR_W-1:0] br_target,
  output logic              dec_valid,
  output logic [ADDR_W-1:0] dec_pc,
  output logic [INSN_W-1:0] dec_instr
);

  localparam int unsigned STEP = INSN_W / 8;

  logic              hold;
  logic              issue;
  logic [ADDR_W-1:0] issue_pc;
  logic              src_valid;
  logic [ADDR_W-1:0] src_pc;
  logic [INSN_W-1:0] src_word;

  assign hold      = ~dec_ready;
  assign imem_req  = issue;
  assign imem_addr = issue_pc;

  fe_pc_gen #(
    .ADDR_W(ADDR_W), .STEP(STEP), .RESET_VEC(RESET_VEC)
  ) u_pc (
    .clk(clk), .rst(rst), .hold(hold),
    .redirect(br_taken), .redirect_pc(br_target),
    .issue(issue), .issue_pc(issue_pc)
  );

  fe_resp_track #(
    .ADDR_W(ADDR_W), .INSN_W(INSN_W)
  ) u_resp (
    .clk(clk), .rst(rst), .hold(hold), .redirect(br_taken),
    .issue(issue), .issue_pc(issue_pc), .mem_word(imem_rdata),
    .src_valid(src_valid), .src_pc(src_pc), .src_word(src_word)
  );

  fe_dec_stage #(
    .ADDR_W(ADDR_W), .INSN_W(INSN_W), .RESOLVE(RESOLVE)
  ) u_dec (
    .clk(clk), .rst(rst), .hold(hold), .redirect(br_taken),
    .src_valid(src_valid), .src_pc(src_pc), .src_word(src_word),
    .out_valid(dec_valid), .out_pc(dec_pc), .out_word(dec_instr)
  );

endmodule

// File: rtl/fetch_frontend_chk.sv
module fetch_frontend_chk
  import fe_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       INSN_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0,
  parameter fe_resolve_e       RESOLVE   = RESOLVE_DECODE
) (
  input logic              clk,
  input logic              rst,
  input logic              imem_req,
  input logic [ADDR_W-1:0] imem_addr,
  input logic              dec_ready,
  input logic              br_taken,
  input logic [ADDR_W-1:0] br_target,
  input logic              dec_valid,
  input logic [ADDR_W-1:0] dec_pc,
  input logic [INSN_W-1:0] dec_instr
);

  localparam logic [ADDR_W-1:0] INC = ADDR_W'(INSN_W / 8);

  // R1
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    imem_req |=> (imem_addr == $past(imem_addr) + INC));

  // R2
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dec_valid && imem_addr == RESET_VEC));

  // R4
  redirect_addr_chk: assert property (@(posedge clk) disable iff (rst)
    br_taken |=> (imem_addr == $past(br_target)));

  // R7
  flush_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    br_taken |=> !dec_valid);

  // R8
  hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (!dec_ready && !br_taken) |=> $stable(imem_addr));

  // R8
  hold_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_ready && !br_taken) |=>
      ($stable(dec_pc) && $stable(dec_instr) && (dec_valid || br_taken)));

  generate
    if (RESOLVE == RESOLVE_EXECUTE) begin : g_late
      // R6
      late_kill_chk: assert property (@(posedge clk) disable iff (rst)
        br_taken |-> !dec_valid);
    end
  endgenerate

endmodule

bind fetch_frontend fetch_frontend_chk #(
  .ADDR_W(ADDR_W), .INSN_W(INSN_W), .RESET_VEC(RESET_VEC), .RESOLVE(RESOLVE)
) u_chk (
  .clk(clk), .rst(rst), .imem_req(imem_req), .imem_addr(imem_addr),
  .dec_ready(dec_ready), .br_taken(br_taken), .br_target(br_target),
  .dec_valid(dec_valid), .dec_pc(dec_pc), .dec_instr(dec_instr)
);

// File: tb/sim_fetch_lane.sv
// One front end under a behavioural model; the mode picks the branch timing.
module sim_fetch_lane
  import fe_pkg::*;
#(
  parameter fe_resolve_e MODE = RESOLVE_DECODE,
  parameter logic [31:0] RV   = 32'h0000_1000
) (
  input logic clk,
  input logic rst
);

  localparam bit LATE = (MODE == RESOLVE_EXECUTE);
  localparam int PEN  = LATE ? 3 : 2;

  logic        dec_ready = 1'b1;
  logic        br_taken  = 1'b0;
  logic [31:0] br_target = '0;
  logic        imem_req;
  logic [31:0] imem_addr;
  logic [31:0] imem_rdata;
  logic        dec_valid;
  logic [31:0] dec_pc;
  logic [31:0] dec_instr;

  int n_chk = 0, n_fail = 0, n_acc = 0, n_pen = 0, n_hit = 0;

  function automatic logic [31:0] wordf(input logic [31:0] a);
    return {a[7:0], a[31:8]} ^ 32'h9E37_79B9;
  endfunction
  function automatic bit is_br(input logic [31:0] a);
    return a[5:2] == 4'd7;
  endfunction
  function automatic logic [31:0] tgt(input logic [31:0] a);
    return (a[9:6] == 4'hF) ? RV + 32'h10 : a + 32'h44;
  endfunction
  function automatic bit stall_pat(input int c);
    return (c % 11 == 6) || ((c % 37) >= 20 && (c % 37) <= 23);
  endfunction

  always @(posedge clk) imem_rdata <= wordf(imem_addr);

  fetch_frontend #(
    .ADDR_W(32), .INSN_W(32), .RESET_VEC(RV), .RESOLVE(MODE)
  ) u0 (
    .clk(clk), .rst(rst), .imem_req(imem_req), .imem_addr(imem_addr),
    .imem_rdata(imem_rdata), .dec_ready(dec_ready), .br_taken(br_taken),
    .br_target(br_target), .dec_valid(dec_valid), .dec_pc(dec_pc),
    .dec_instr(dec_instr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s late=%0d t=%0t actual=%h expected=%h", req, LATE, $time, act, exp);
    end
  endtask

  initial begin
    int          cyc = 0;
    bit          first = 1'b1;
    logic [31:0] exp_pc = RV;
    bit          pend_br = 1'b0;
    logic [31:0] pend_tgt = '0;
    bit          in_win = 1'b0, win_stall = 1'b0, force_stall = 1'b0;
    int          br_cyc = 0, nbr = 0;
    bit          p_req = 1'b0, p_br = 1'b0, p_rdy = 1'b1, p_dv = 1'b0;
    logic [31:0] p_addr = '0, p_tgt = '0, p_dpc = '0, p_dins = '0;
    forever begin
      @(negedge clk);
      if (rst) begin
        dec_ready = 1'b1; br_taken = 1'b0;
        #1;
        chk(!dec_valid, "R2 valid in reset", 32'(dec_valid), 0);
        chk(imem_addr == RV, "R2 pc in reset", imem_addr, RV);
        first = 1'b1;
        continue;
      end
      // drive this cycle's inputs
      dec_ready = !(force_stall || stall_pat(cyc));
      force_stall = 1'b0;
      if (LATE) begin
        br_taken = pend_br; br_target = pend_tgt; pend_br = 1'b0;
      end else begin
        br_taken  = dec_valid && dec_ready && is_br(dec_pc);
        br_target = tgt(dec_pc);
      end
      #1;
      if (in_win && !dec_ready) win_stall = 1'b1;
      // fetch side
      if (first) begin
        chk(imem_addr == RV && imem_req == dec_ready, "R2 first fetch", imem_addr, RV);
        first = 1'b0;
      end else if (p_br) begin
        chk(imem_addr == p_tgt, p_rdy ? "R4 redirect" : "R9 redirect under stall",
            imem_addr, p_tgt);
        if (!p_rdy) n_hit++;
      end else if (p_req) begin
        chk(imem_addr == p_addr + 4, "R1 step", imem_addr, p_addr + 4);
      end else begin
        chk(imem_addr == p_addr, "R8 pc frozen", imem_addr, p_addr);
      end
      if (!dec_ready && !br_taken)
        chk(!imem_req, "R8 no request held", 32'(imem_req), 0);
      // decode side
      if (p_dv && !p_rdy && !p_br) begin
        chk(dec_pc == p_dpc && dec_instr == p_dins && (dec_valid || br_taken),
            "R8 decode held", dec_pc, p_dpc);
      end
      if (LATE && br_taken)
        chk(!dec_valid, "R6 kill in redirect cycle", 32'(dec_valid), 0);
      if (dec_valid && dec_ready) begin
        n_acc++;
        chk(dec_pc == exp_pc, "R3 R7 order", dec_pc, exp_pc);
        chk(dec_instr == wordf(dec_pc), "R3 word", dec_instr, wordf(dec_pc));
        if (in_win) begin
          if (!win_stall) begin
            n_pen++;
            chk(cyc - br_cyc - 1 == PEN, LATE ? "R6 penalty" : "R5 penalty",
                32'(cyc - br_cyc - 1), 32'(PEN));
          end
          in_win = 1'b0;
        end
        if (is_br(dec_pc)) begin
          exp_pc = tgt(dec_pc);
          br_cyc = cyc; in_win = 1'b1; win_stall = 1'b0;
          nbr++;
          if (nbr % 3 == 1) force_stall = 1'b1;
          if (LATE) begin pend_br = 1'b1; pend_tgt = tgt(dec_pc); end
        end else begin
          exp_pc = exp_pc + 4;
        end
      end
      p_req = imem_req; p_addr = imem_addr; p_br = br_taken; p_tgt = br_target;
      p_rdy = dec_ready; p_dv = dec_valid; p_dpc = dec_pc; p_dins = dec_instr;
      cyc++;
    end
  end

endmodule

// File: tb/sim_fetch_frontend.sv
module sim_fetch_frontend;
  import fe_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;   // 250 MHz

  sim_fetch_lane #(.MODE(RESOLVE_DECODE))  la (.clk(clk), .rst(rst));
  sim_fetch_lane #(.MODE(RESOLVE_EXECUTE)) lb (.clk(clk), .rst(rst));

  int t_chk = 0, t_fail = 0;

  task automatic tchk(input bit ok, input string req, input int act, input int exp);
    t_chk++;
    if (!ok) begin
      t_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    bit timeout = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    fork
      begin repeat (3000) @(posedge clk); end
      begin repeat (20000) @(posedge clk); timeout = 1'b1; end
    join_any
    disable fork;
    @(negedge clk); #2;
    tchk(!timeout, "watchdog", 32'(timeout), 0);
    tchk(la.n_acc > 1000, "R3 early throughput", la.n_acc, 1000);
    tchk(lb.n_acc > 1000, "R3 late throughput", lb.n_acc, 1000);
    tchk(la.n_pen >= 5, "R5 penalty samples", la.n_pen, 5);
    tchk(lb.n_pen >= 5, "R6 penalty samples", lb.n_pen, 5);
    tchk(lb.n_hit >= 1, "R9 redirect with stall seen", lb.n_hit, 1);
    t_chk  += la.n_chk + lb.n_chk;
    t_fail += la.n_fail + lb.n_fail;
    $display("%0d/%0d checks passed", t_chk - t_fail, t_chk);
    $finish;
  end

endmodule